// File: doc/BRIEF.md
# Serial Audio Word Transmitter with Mute

The block sends 16-bit audio words one bit at a time, most significant bit first. A host writes each word into a one-entry holding register. The block moves the held word into its shift register at every word boundary. It drives a serial data line, a bit clock and a word-select line that marks the left and right channel slots. Everything runs in the oversampling clock domain. A programmable ratio sets the bit period as a whole number of oversampling cycles, and the choices include the non-power-of-two ratios 6 and 12. An input pin can instead hand bit timing to an external bit clock.

Muting silences the data line only. The counters keep running, words keep being consumed, and a missing word is still caught. If the holding register is empty when a word is due, zeros are sent and a sticky underflow flag rises. The host clears that flag with a one-cycle pulse. Putting the block in receive mode, or clearing its enable, stops transmission. Clearing the enable also empties the holding register.

Top module: `aud_ser_tx`

## Requirements
- R1: After a synchronous active-low reset, sd_o, bclk_o, ws_o, uflow and ctl_rdata are 0 and td_empty is 1.
- R2: The control register holds a 3-bit ratio code in bits [2:0]:
  - codes 0 to 6 give bit periods of 1, 2, 4, 8, 16, 6 and 12 oversampling cycles;
  - code 7 behaves as ratio 1.
  
  With internal timing (clk_gen_sel=1), bclk_o is low for the first ratio/2 cycles of each bit period and high for the rest. At ratio 1 it stays high while transmitting.
- R3: With clk_gen_sel=0 the ratio code is ignored. A bit period ends on each cycle where ext_bclk_i is 1 and was 0 in the previous cycle. While transmitting, bclk_o repeats ext_bclk_i one cycle late.
- R4: Transmission runs when control bit 4 (enable) and bit 3 (1 = transmit) are both 1. On the first clock edge that sees both set, a word is loaded. Its MSB appears on sd_o right after that edge. Each following bit appears after a further bit period, 16 bits per word. The next word loads at the end of the 16th bit.
- R5: ws_o is 0 when transmission starts and toggles at every later word load.
- R6: A write (td_wr) while enabled fills the one-entry holding register and clears td_empty. A write while full replaces the held word. A load empties the register unless a write arrives on the same edge, in which case the new word is kept.
- R7: A load that finds the holding register empty sends an all-zero word and sets uflow. uflow stays set until a uf_clr pulse. A new underflow on the same edge as uf_clr wins.
- R8: Control bit 6 (mute) forces sd_o to 0. Bit timing, ws_o, word consumption and underflow detection carry on exactly as if unmuted.
- R9: One edge after the register shows enable=0 or receive mode, sd_o, bclk_o and ws_o are 0. While enable=0 the holding register is emptied and writes to it are ignored.
- R10: ctl_rdata returns the control register. Bit 5 is reserved and always reads 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 7 | Control write data ([2:0] ratio, 3 transmit, 4 enable, 5 reserved, 6 mute) |
| ctl_rdata | output | 7 | Control register readback |
| clk_gen_sel | input | 1 | 1: internal ratio divider, 0: external bit clock |
| ext_bclk_i | input | 1 | External bit clock, synchronous to clk |
| td_wr | input | 1 | Holding register write strobe |
| td_wdata | input | 16 | Word to transmit |
| td_empty | output | 1 | Holding register is empty |
| uf_clr | input | 1 | Clears the underflow flag |
| uflow | output | 1 | Sticky underflow flag |
| sd_o | output | 1 | Serial data |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |

## Verification
The bench sweeps all eight ratio codes. A divider that counted the 6 and 12 ratios wrong, or mistreated code 7, would shift the serial bits and the bit-clock duty against the reference at once. It keeps transmitting while muted and without feeding words. A mute that gated the load path would fail to set uflow, or would leave stale words in the holding register. It also exercises two write-ordering cases: a double write while full, and a write on the same edge as a load. Finally, it drops to receive mode and to disable with words pending, which catches a flush applied in the wrong mode or outputs that fail to go quiet.

// File: rtl/aud_tx_pkg.sv
// Shared types and helpers for the serial audio transmitter.
// Assumes a 7-bit control word; the field layout below is the software view.
package aud_tx_pkg;

    localparam int CTL_W = 7;

    // Control register layout, MSB first.
    typedef struct packed {
        logic       mute;     // bit 6: silence serial data
        logic       rsvd;     // bit 5: reserved, reads 0
        logic       enable;   // bit 4: block on
        logic       tx;       // bit 3: 1 transmit, 0 receive
        logic [2:0] code;     // bits 2:0: bit-period ratio code
    } ctl_t;

    // Bit-period length in oversampling cycles for a ratio code.
    function automatic int unsigned ratio_of(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 8;
            3'd4:    return 16;
            3'd5:    return 6;
            3'd6:    return 12;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/aud_tx_regs.sv
// Host-facing storage: control register, one-entry holding register, and
// the sticky underflow flag. Assumes load_i is a one-cycle pulse from the
// shifter marking a word boundary.
module aud_tx_regs
    import aud_tx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              td_wr,
    input  logic [WORD_W-1:0] td_wdata,
    input  logic              uf_clr,
    input  logic              load_i,
    output ctl_t              ctl_o,
    output logic              hold_full_o,
    output logic [WORD_W-1:0] hold_data_o,
    output logic              uflow_o
);

    ctl_t              ctl_q;
    logic              full_q;
    logic [WORD_W-1:0] data_q;
    logic              uf_q;
    ctl_t              ctl_in;

    // Strip the reserved bit from incoming control data.
    always_comb begin
        ctl_in      = ctl_t'(ctl_wdata);
        ctl_in.rsvd = 1'b0;
    end

    // Control register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q <= ctl_in;
        end
    end

    // Holding register: flushed while disabled, write beats load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (!ctl_q.enable) begin
            full_q <= 1'b0;
        end else if (td_wr) begin
            full_q <= 1'b1;
            data_q <= td_wdata;
        end else if (load_i) begin
            full_q <= 1'b0;
        end
    end

    // Sticky underflow: set on an empty load, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_q <= 1'b0;
        end else if (load_i && !full_q) begin
            uf_q <= 1'b1;
        end else if (uf_clr) begin
            uf_q <= 1'b0;
        end
    end

    assign ctl_o       = ctl_q;
    assign hold_full_o = full_q;
    assign hold_data_o = data_q;
    assign uflow_o     = uf_q;

endmodule

// File: rtl/aud_tx_bitclk.sv
// Bit timing: either divides the oversampling clock by the selected ratio
// or edge-detects an external bit clock. Produces a one-cycle bit_end_o
// pulse on the last cycle of each bit period and the bclk_o pin level.
// Assumes ext_bclk_i is already synchronous to clk.
module aud_tx_bitclk
    import aud_tx_pkg::*;
#(
    parameter int MAX_RATIO = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active_i,
    input  logic       int_gen_i,
    input  logic [2:0] code_i,
    input  logic       ext_bclk_i,
    output logic       bit_end_o,
    output logic       bclk_o
);

    localparam int CNT_W = $clog2(MAX_RATIO);

    logic [CNT_W-1:0] ph_q;
    logic             ext_q;
    int unsigned      ratio;
    logic             int_end;
    logic             int_high;

    // Decode ratio and compare phase against its end and mid points.
    always_comb begin
        ratio    = ratio_of(code_i);
        int_end  = (32'(ph_q) >= ratio - 1);
        int_high = (32'(ph_q) >= ratio / 2);
    end

    // Phase counter within a bit period; idle at zero when inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            ph_q <= '0;
        end else if (int_gen_i) begin
            ph_q <= int_end ? '0 : ph_q + 1'b1;
        end
    end

    // Previous external bit-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
        end else begin
            ext_q <= ext_bclk_i;
        end
    end

    assign bit_end_o = int_gen_i ? int_end : (ext_bclk_i & ~ext_q);
    assign bclk_o    = active_i & (int_gen_i ? int_high : ext_q);

endmodule

// File: rtl/aud_tx_shifter.sv
// Word framing and serialisation: loads a word on start and after every
// WORD_W bit periods, shifts MSB first, toggles word select per word.
// Assumes bit_end_i is a one-cycle pulse per bit period.
module aud_tx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              mute_i,
    input  logic              bit_end_i,
    input  logic              hold_full_i,
    input  logic [WORD_W-1:0] hold_data_i,
    output logic              load_o,
    output logic              active_o,
    output logic              sd_o,
    output logic              ws_o
);

    localparam int BC_W = $clog2(WORD_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(WORD_W - 1);

    logic              active_q;
    logic [BC_W-1:0]   bc_q;
    logic              ws_q;
    logic [WORD_W-1:0] sh_q;
    logic              word_end;
    logic [WORD_W-1:0] next_word;

    // Word boundary detection and the word to load there.
    always_comb begin
        word_end  = bit_end_i && (bc_q == LAST_BIT);
        load_o    = run_i && (!active_q || word_end);
        next_word = hold_full_i ? hold_data_i : '0;
    end

    // Framing state: start, shift, and word reload.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            active_q <= 1'b0;
            bc_q     <= '0;
            ws_q     <= 1'b0;
            sh_q     <= '0;
        end else if (!active_q) begin
            active_q <= 1'b1;
            bc_q     <= '0;
            ws_q     <= 1'b0;
            sh_q     <= next_word;
        end else if (word_end) begin
            bc_q     <= '0;
            ws_q     <= ~ws_q;
            sh_q     <= next_word;
        end else if (bit_end_i) begin
            bc_q     <= bc_q + 1'b1;
            sh_q     <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    assign active_o = active_q;
    assign sd_o     = active_q & ~mute_i & sh_q[WORD_W-1];
    assign ws_o     = ws_q;

endmodule

// File: rtl/aud_ser_tx.sv
// Top of the serial audio transmitter. Wires host storage, bit timing and
// the shifter together. Single clock domain: clk is the oversampling clock.
module aud_ser_tx
    import aud_tx_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int MAX_RATIO = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              clk_gen_sel,
    input  logic              ext_bclk_i,
    input  logic              td_wr,
    input  logic [WORD_W-1:0] td_wdata,
    output logic              td_empty,
    input  logic              uf_clr,
    output logic              uflow,
    output logic              sd_o,
    output logic              bclk_o,
    output logic              ws_o
);

    ctl_t              ctl;
    logic              hold_full;
    logic [WORD_W-1:0] hold_data;
    logic              load;
    logic              active;
    logic              bit_end;
    logic              run;

    assign run       = ctl.enable & ctl.tx;
    assign ctl_rdata = CTL_W'(ctl);
    assign td_empty  = ~hold_full;

    aud_tx_regs #(.WORD_W(WORD_W)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .td_wr       (td_wr),
        .td_wdata    (td_wdata),
        .uf_clr      (uf_clr),
        .load_i      (load),
        .ctl_o       (ctl),
        .hold_full_o (hold_full),
        .hold_data_o (hold_data),
        .uflow_o     (uflow)
    );

    aud_tx_bitclk #(.MAX_RATIO(MAX_RATIO)) i_bitclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .int_gen_i  (clk_gen_sel),
        .code_i     (ctl.code),
        .ext_bclk_i (ext_bclk_i),
        .bit_end_o  (bit_end),
        .bclk_o     (bclk_o)
    );

    aud_tx_shifter #(.WORD_W(WORD_W)) i_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .mute_i      (ctl.mute),
        .bit_end_i   (bit_end),
        .hold_full_i (hold_full),
        .hold_data_i (hold_data),
        .load_o      (load),
        .active_o    (active),
        .sd_o        (sd_o),
        .ws_o        (ws_o)
    );

endmodule

// File: rtl/aud_ser_tx_chk.sv
// Port-level temporal checks for aud_ser_tx, attached by bind.
module aud_ser_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] ctl_rdata,
    input logic       td_wr,
    input logic       td_empty,
    input logic       uf_clr,
    input logic       uflow,
    input logic       sd_o,
    input logic       bclk_o,
    input logic       ws_o
);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_rdata[4] && ctl_rdata[3]) |=> (!sd_o && !bclk_o && !ws_o));

    // R9
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[4] |=> td_empty);

    // R8
    mute_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[6] |-> !sd_o);

    // R6
    hold_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (td_wr && ctl_rdata[4]) |=> !td_empty);

    // R7
    uf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && !uf_clr) |=> uflow);

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !ctl_rdata[5]);

endmodule

bind aud_ser_tx aud_ser_tx_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_rdata (ctl_rdata),
    .td_wr     (td_wr),
    .td_empty  (td_empty),
    .uf_clr    (uf_clr),
    .uflow     (uflow),
    .sd_o      (sd_o),
    .bclk_o    (bclk_o),
    .ws_o      (ws_o)
);

// File: tb/test_aud_ser_tx.sv
`timescale 1ns/1ps
module test_aud_ser_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [6:0]  ctl_wdata = '0;
    logic [6:0]  ctl_rdata;
    logic        clk_gen_sel = 1'b1;
    logic        ext_bclk = 1'b0;
    logic        td_wr = 1'b0;
    logic [15:0] td_wdata = '0;
    logic        td_empty;
    logic        uf_clr = 1'b0;
    logic        uflow;
    logic        sd_o;
    logic        bclk_o;
    logic        ws_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    logic [15:0] pat = 16'hACE1;

    always #2 clk = ~clk;

    aud_ser_tx i_aud_ser_tx (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .clk_gen_sel(clk_gen_sel), .ext_bclk_i(ext_bclk),
        .td_wr(td_wr), .td_wdata(td_wdata), .td_empty(td_empty), .uf_clr(uf_clr),
        .uflow(uflow), .sd_o(sd_o), .bclk_o(bclk_o), .ws_o(ws_o)
    );

    // Behavioural reference state.
    logic [6:0]  m_ctl = '0;
    bit          m_active = 0;
    int          m_ph = 0;
    int          m_bc = 0;
    bit          m_ws = 0;
    logic [15:0] m_word = '0;
    logic [15:0] m_q[$];
    bit          m_uf = 0;
    bit          m_extp = 0;
    bit          m_started = 0;

    function automatic int ratio_ref(input int c);
        case (c)
            0: return 1;  1: return 2;  2: return 4;  3: return 8;
            4: return 16; 5: return 6;  6: return 12; default: return 1;
        endcase
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // Reference model advance on every clock edge.
    always @(posedge clk) begin : model
        bit en, run, bend, load;
        int r;
        m_started = 1;
        if (!rst_n) begin
            m_ctl = '0; m_active = 0; m_ph = 0; m_bc = 0; m_ws = 0;
            m_word = '0; m_q.delete(); m_uf = 0; m_extp = 0;
        end else begin
            en   = m_ctl[4];
            run  = m_ctl[4] && m_ctl[3];
            r    = ratio_ref(int'(m_ctl[2:0]));
            bend = clk_gen_sel ? (m_ph >= r - 1) : (ext_bclk && !m_extp);
            load = 0;
            if (!run) begin
                m_active = 0; m_ph = 0; m_bc = 0; m_ws = 0; m_word = '0;
            end else if (!m_active) begin
                m_active = 1; m_ph = 0; m_bc = 0; m_ws = 0; load = 1;
            end else begin
                if (clk_gen_sel) m_ph = bend ? 0 : m_ph + 1;
                if (bend) begin
                    if (m_bc == 15) begin
                        load = 1; m_bc = 0; m_ws = !m_ws;
                    end else begin
                        m_word = m_word << 1; m_bc++;
                    end
                end
            end
            if (load) m_word = (m_q.size() > 0) ? m_q[0] : 16'h0;
            if (load && m_q.size() == 0) m_uf = 1;
            else if (uf_clr) m_uf = 0;
            if (!en) m_q.delete();
            else begin
                if (load && m_q.size() > 0) void'(m_q.pop_front());
                if (td_wr) begin m_q.delete(); m_q.push_back(td_wdata); end
            end
            if (ctl_wr) m_ctl = ctl_wdata & 7'h5f;
            m_extp = ext_bclk;
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (m_started && !done) begin
            int r;
            bit e_bclk, e_sd;
            r      = ratio_ref(int'(m_ctl[2:0]));
            e_bclk = m_active && (clk_gen_sel ? (m_ph >= r / 2) : m_extp);
            e_sd   = m_active && !m_ctl[6] && m_word[15];
            chk(16'(sd_o), 16'(e_sd), !m_active ? "R9" : (m_ctl[6] ? "R8" : "R4"));
            chk(16'(bclk_o), 16'(e_bclk), clk_gen_sel ? "R2" : "R3");
            chk(16'(ws_o), 16'(m_ws), "R5");
            chk(16'(td_empty), 16'(m_q.size() == 0), "R6");
            chk(16'(uflow), 16'(m_uf), "R7");
            chk(16'(ctl_rdata), 16'(m_ctl), "R10");
        end
    end

    task automatic idle_inputs();
        ctl_wr = 0; td_wr = 0; uf_clr = 0;
    endtask

    task automatic write_ctl(input logic [6:0] v);
        @(posedge clk); #1;
        idle_inputs();
        ctl_wr = 1; ctl_wdata = v;
    endtask

    task automatic run(input int n, input bit feed, input int extp);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            idle_inputs();
            if (extp > 0 && (i % extp) == 0) ext_bclk = ~ext_bclk;
            if (feed && td_empty) begin
                td_wr = 1; td_wdata = pat;
                pat = {pat[14:0], pat[15] ^ pat[13] ^ pat[12] ^ pat[10]};
            end
        end
    endtask

    task automatic pulse_clear();
        @(posedge clk); #1;
        idle_inputs();
        uf_clr = 1;
        @(posedge clk); #1;
        idle_inputs();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(16'({sd_o, bclk_o, ws_o, uflow}), 16'h0, "R1");
        chk(16'(td_empty), 16'h1, "R1");
        chk(16'(ctl_rdata), 16'h0, "R1");

        // R10: reserved bit reads back 0
        write_ctl(7'h7f);
        run(1, 0, 0);
        @(negedge clk);
        chk(16'(ctl_rdata), 16'h5f, "R10");
        run(40, 0, 0);
        write_ctl(7'h00);
        run(3, 0, 0);
        pulse_clear();

        // R2 / R4 / R5: every ratio code, fed continuously
        for (int c = 0; c < 8; c++) begin
            write_ctl(7'h18 | 7'(c));
            run(36 * ratio_ref(c) + 20, 1, 0);
            write_ctl(7'h00);
            run(4, 0, 0);
        end
        @(negedge clk);
        // R7: first load after each start found the register empty
        chk(16'(uflow), 16'h1, "R7");
        pulse_clear();
        @(negedge clk);
        chk(16'(uflow), 16'h0, "R7");

        // R8: muted at ratio 2 with feed, then without feed
        write_ctl(7'h59);
        run(200, 1, 0);
        pulse_clear();
        run(120, 0, 0);
        @(negedge clk);
        chk(16'(uflow), 16'h1, "R8");
        chk(16'(sd_o), 16'h0, "R8");
        write_ctl(7'h00);
        run(3, 0, 0);
        pulse_clear();

        // R3: external bit clock, ratio code ignored
        @(posedge clk); #1 clk_gen_sel = 0;
        write_ctl(7'h1b);
        run(400, 1, 3);
        write_ctl(7'h00);
        run(4, 0, 0);
        @(posedge clk); #1 clk_gen_sel = 1;

        // R6: double write while full, then load
        write_ctl(7'h1c);
        run(5, 0, 0);
        @(posedge clk); #1 idle_inputs(); td_wr = 1; td_wdata = 16'h1234;
        @(posedge clk); #1 idle_inputs(); td_wr = 1; td_wdata = 16'hF0A5;
        @(posedge clk); #1 idle_inputs();
        @(negedge clk);
        chk(16'(td_empty), 16'h0, "R6");
        run(600, 1, 0);

        // R9: receive mode stops output; disable flushes and ignores writes
        write_ctl(7'h10);
        run(20, 1, 0);
        @(negedge clk);
        chk(16'({sd_o, bclk_o, ws_o}), 16'h0, "R9");
        write_ctl(7'h00);
        run(2, 0, 0);
        @(posedge clk); #1 idle_inputs(); td_wr = 1; td_wdata = 16'hBEEF;
        @(posedge clk); #1 idle_inputs();
        @(negedge clk);
        chk(16'(td_empty), 16'h1, "R9");
        run(5, 0, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule